// File: doc/BRIEF.md
# Store-Window Hint Ingress Dispatcher

This block sits beside the core-side store stream of a programmable prefetch engine. It watches each store presented to it and picks out the uncacheable stores that land inside a single reserved 4 KiB page. Each such store becomes a hint event. The 64-bit store data is the virtual address to prefetch, and a small selector field taken from the store address picks one of `N` handler slots. Stores outside the page, and cacheable stores even inside it, pass by without effect. In-page uncacheable stores that are malformed are consumed, dropped and tallied.

A second input carries prefetch-response events coming back from the cache side. The block merges responses and hints into one dispatch stream, a single registered record on a valid/ready interface with a kind bit, a handler index and a 64-bit payload. A response always beats a hint that arrives in the same cycle. When the dispatch output stalls, both inputs are held off, so no event is lost.

The output stage is a two-state machine. `OUT_EMPTY` means no record is held. It moves to `OUT_FULL` when an event is loaded and otherwise stays put. `OUT_FULL` presents the record. It stays in `OUT_FULL` while the consumer is not ready, or when the consumer takes the record and a new event is loaded in the same cycle. It returns to `OUT_EMPTY` when the consumer takes the record and nothing new is loaded.

Top module: `hint_ingress_dispatch`

## Requirements
- R1: After reset, `ev_valid` is 0, `err_count` is 0, and both `st_ready` and `rsp_ready` are 1 while no response is offered.
- R2: An accepted store with `st_uncached`=1 that is inside the page (`st_addr[ADDR_W-1:12]` equals the page base), has `st_addr[2:0]`=0, has `st_addr[11:3+SEL_W]`=0 and has selector `st_addr[3+SEL_W-1:3]` < N produces one event. That event has `ev_type`=0 (hint), `ev_handler` equal to the selector and `ev_payload` equal to `st_data`.
- R3: An accepted store that is outside the page, or has `st_uncached`=0, produces no event and leaves `err_count` unchanged.
- R4: An accepted in-page uncacheable store that is misaligned, has a nonzero bit in `st_addr[11:3+SEL_W]`, or has a selector of N or above produces no event and increments `err_count` by one.
- R5: An accepted response produces one event with `ev_type`=1, `ev_handler`=`rsp_handler` and `ev_payload`=`rsp_data`.
- R6: While `rsp_valid` is 1, `st_ready` is 0, so a response is always taken ahead of a store offered in the same cycle.
- R7: While `ev_valid`=1 and `ev_ready`=0, the record stays valid and `ev_type`, `ev_handler` and `ev_payload` hold their values into the next cycle.
- R8: While the output is stalled (`ev_valid`=1, `ev_ready`=0), `st_ready` and `rsp_ready` are 0. Every accepted hint and response leaves the output exactly once, in acceptance order.
- R9: An event accepted at a clock edge is presented with `ev_valid`=1 right after that edge. With `ev_ready` held at 1, one event per cycle passes.
- R10: `err_count` saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | ADDR_W | Store physical address |
| st_data | input | 64 | Store data (prefetch virtual address) |
| st_uncached | input | 1 | Store is uncacheable |
| rsp_valid | input | 1 | Prefetch response offered |
| rsp_ready | output | 1 | Response accepted this cycle when valid |
| rsp_handler | input | SEL_W | Handler slot for the response |
| rsp_data | input | 64 | Response payload |
| ev_valid | output | 1 | Dispatch record valid |
| ev_ready | input | 1 | Dispatch consumer ready |
| ev_type | output | 1 | 0 hint, 1 response |
| ev_handler | output | SEL_W | Selected handler slot |
| ev_payload | output | 64 | Event payload |
| err_count | output | CNT_W | Saturating count of dropped malformed hint stores |

## Verification
The bench goes after the collision of a response and a store in the same cycle. A design that let both through would lose the hint or duplicate the response, and the in-order event model would flag it. Long output stalls check that neither input is accepted while the record is held. A design that kept accepting would drop events or change the held record. Stores that miss the page, that are cacheable, that sit at the boundary selector values N-1 and N, that are misaligned, or that set upper offset bits separate the ignore, dispatch and error paths. A wrong decode would show up as a phantom event or as a shifted error count. A long run of malformed stores drives the counter to its ceiling, where a wrapping counter would read back zero.

// File: rtl/hid_pkg.sv
package hid_pkg;

    typedef enum logic {
        EV_HINT = 1'b0,
        EV_RESP = 1'b1
    } ev_kind_t;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_t;

endpackage

// File: rtl/hid_store_decode.sv
module hid_store_decode #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned N      = 12,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 48'h0000_7fff_3000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              uncached,
    output logic              is_hint,
    output logic              is_bad,
    output logic [SEL_W-1:0]  sel
);
    localparam int unsigned PAGE_LSB = 12;
    localparam int unsigned SEL_LSB  = 3;
    localparam int unsigned HI_LSB   = SEL_LSB + SEL_W;
    localparam int unsigned HI_W     = PAGE_LSB - HI_LSB;

    logic in_page;
    logic aligned;
    logic hi_clear;
    logic sel_ok;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_clear = (addr[PAGE_LSB-1:HI_LSB] == '0);
        end else begin : g_nohi
            assign hi_clear = 1'b1;
        end
    endgenerate

    assign sel      = addr[HI_LSB-1:SEL_LSB];
    assign in_page  = uncached && (addr[ADDR_W-1:PAGE_LSB] == PAGE_BASE[ADDR_W-1:PAGE_LSB]);
    assign aligned  = (addr[SEL_LSB-1:0] == '0);
    assign sel_ok   = (32'(sel) < N);
    assign is_hint  = in_page && aligned && hi_clear && sel_ok;
    assign is_bad   = in_page && !(aligned && hi_clear && sel_ok);

endmodule

// File: rtl/hid_arbiter.sv
module hid_arbiter
    import hid_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic             stall,
    input  logic             st_valid,
    input  logic             st_hint,
    input  logic             st_bad,
    input  logic [SEL_W-1:0] st_sel,
    input  logic [63:0]      st_data,
    input  logic             rsp_valid,
    input  logic [SEL_W-1:0] rsp_sel,
    input  logic [63:0]      rsp_data,
    output logic             st_ready,
    output logic             rsp_ready,
    output logic             load,
    output ev_kind_t         load_kind,
    output logic [SEL_W-1:0] load_sel,
    output logic [63:0]      load_data,
    output logic             err_inc
);
    logic take_rsp;
    logic take_st;

    always_comb begin
        rsp_ready = !stall;
        st_ready  = !stall && !rsp_valid;
        take_rsp  = rsp_valid && !stall;
        take_st   = st_valid && st_ready && st_hint;
        load      = take_rsp || take_st;
        err_inc   = st_valid && st_ready && st_bad;
        if (take_rsp) begin
            load_kind = EV_RESP;
            load_sel  = rsp_sel;
            load_data = rsp_data;
        end else begin
            load_kind = EV_HINT;
            load_sel  = st_sel;
            load_data = st_data;
        end
    end

endmodule

// File: rtl/hid_out_stage.sv
module hid_out_stage
    import hid_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  ev_kind_t         load_kind,
    input  logic [SEL_W-1:0] load_sel,
    input  logic [63:0]      load_data,
    input  logic             ev_ready,
    output logic             ev_valid,
    output logic             stall,
    output logic             ev_type,
    output logic [SEL_W-1:0] ev_handler,
    output logic [63:0]      ev_payload
);
    out_state_t state_q;
    out_state_t state_d;
    ev_kind_t   kind_q;
    logic [SEL_W-1:0] sel_q;
    logic [63:0]      data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= EV_HINT;
            sel_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            kind_q <= load_kind;
            sel_q  <= load_sel;
            data_q <= load_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: state_d = load ? OUT_FULL : OUT_EMPTY;
            OUT_FULL: begin
                if (ev_ready) begin
                    state_d = load ? OUT_FULL : OUT_EMPTY;
                end else begin
                    state_d = OUT_FULL;
                end
            end
            default: state_d = OUT_EMPTY;
        endcase
    end

    always_comb begin
        ev_valid   = (state_q == OUT_FULL);
        stall      = (state_q == OUT_FULL) && !ev_ready;
        ev_type    = kind_q;
        ev_handler = sel_q;
        ev_payload = data_q;
    end

endmodule

// File: rtl/hid_err_counter.sv
module hid_err_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/hint_ingress_dispatch.sv
module hint_ingress_dispatch
    import hid_pkg::*;
#(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned N      = 12,
    parameter int unsigned CNT_W  = 8,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 48'h0000_7fff_3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [63:0]       st_data,
    input  logic              st_uncached,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [SEL_W-1:0]  rsp_handler,
    input  logic [63:0]       rsp_data,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic              ev_type,
    output logic [SEL_W-1:0]  ev_handler,
    output logic [63:0]       ev_payload,
    output logic [CNT_W-1:0]  err_count
);
    logic             st_hint;
    logic             st_bad;
    logic [SEL_W-1:0] st_sel;
    logic             stall;
    logic             load;
    ev_kind_t         load_kind;
    logic [SEL_W-1:0] load_sel;
    logic [63:0]      load_data;
    logic             err_inc;

    hid_store_decode #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .N(N), .PAGE_BASE(PAGE_BASE)
    ) u_decode (
        .addr(st_addr), .uncached(st_uncached),
        .is_hint(st_hint), .is_bad(st_bad), .sel(st_sel)
    );

    hid_arbiter #(.SEL_W(SEL_W)) u_arb (
        .stall(stall), .st_valid(st_valid), .st_hint(st_hint), .st_bad(st_bad),
        .st_sel(st_sel), .st_data(st_data), .rsp_valid(rsp_valid),
        .rsp_sel(rsp_handler), .rsp_data(rsp_data), .st_ready(st_ready),
        .rsp_ready(rsp_ready), .load(load), .load_kind(load_kind),
        .load_sel(load_sel), .load_data(load_data), .err_inc(err_inc)
    );

    hid_out_stage #(.SEL_W(SEL_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .load_kind(load_kind),
        .load_sel(load_sel), .load_data(load_data), .ev_ready(ev_ready),
        .ev_valid(ev_valid), .stall(stall), .ev_type(ev_type),
        .ev_handler(ev_handler), .ev_payload(ev_payload)
    );

    hid_err_counter #(.CNT_W(CNT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .inc(err_inc), .count(err_count)
    );

endmodule

// File: rtl/hid_ingress_checker.sv
module hid_ingress_checker #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned N     = 12,
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [SEL_W-1:0] rsp_handler,
    input logic [63:0]      rsp_data,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic             ev_type,
    input logic [SEL_W-1:0] ev_handler,
    input logic [63:0]      ev_payload,
    input logic [CNT_W-1:0] err_count
);
    p_hint_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_type) |-> (32'(ev_handler) < N));

    p_err_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> (err_count == CNT_W'($past(err_count) + 1'b1)));

    p_resp_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (ev_valid && ev_type
            && ev_handler == $past(rsp_handler) && ev_payload == $past(rsp_data)));

    p_resp_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !st_ready);

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_type)
            && $stable(ev_handler) && $stable(ev_payload)));

    p_no_take_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |-> (!st_ready && !rsp_ready));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(err_count)) |-> (&err_count));

endmodule

bind hint_ingress_dispatch hid_ingress_checker #(
    .SEL_W(SEL_W), .N(N), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_handler(rsp_handler), .rsp_data(rsp_data),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_type(ev_type),
    .ev_handler(ev_handler), .ev_payload(ev_payload), .err_count(err_count)
);

// File: tb/tb_hint_ingress_dispatch.sv
`timescale 1ns/1ps
module tb_hint_ingress_dispatch;
    localparam int unsigned ADDR_W = 48;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned N      = 12;
    localparam int unsigned CNT_W  = 8;
    localparam logic [ADDR_W-1:0] BASE = 48'h0000_7fff_3000;
    localparam int unsigned REC_W  = 1 + SEL_W + 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, st_uncached = 0, rsp_valid = 0, ev_ready = 0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [63:0] st_data = '0, rsp_data = '0;
    logic [SEL_W-1:0] rsp_handler = '0;
    logic st_ready, rsp_ready, ev_valid, ev_type;
    logic [SEL_W-1:0] ev_handler;
    logic [63:0] ev_payload;
    logic [CNT_W-1:0] err_count;

    always #2 clk = ~clk;

    hint_ingress_dispatch dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_uncached(st_uncached),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_handler(rsp_handler),
        .rsp_data(rsp_data), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_type(ev_type), .ev_handler(ev_handler), .ev_payload(ev_payload),
        .err_count(err_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [REC_W-1:0] exp_q[$];
    int exp_err = 0;
    logic prev_stall = 0;
    logic [REC_W-1:0] prev_rec = '0;
    logic s_st_ready, s_rsp_ready, s_ev_valid;
    logic [REC_W-1:0] s_rec;

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 ignore, 1 hint, 2 malformed
    function automatic int classify(input logic [ADDR_W-1:0] a, input logic unc);
        if (!unc || a[ADDR_W-1:12] != BASE[ADDR_W-1:12]) return 0;
        if (a[2:0] != 0 || a[11:3+SEL_W] != 0 || a[3+:SEL_W] >= N) return 2;
        return 1;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int kind, input int sel);
        logic [ADDR_W-1:0] a;
        a = BASE | ADDR_W'(sel << 3);
        case (kind)
            1: a = a | ADDR_W'(1 + $urandom_range(0, 6));
            2: a = BASE | ADDR_W'($urandom_range(N, (1 << SEL_W) - 1) << 3);
            3: a = a | ADDR_W'(1 << $urandom_range(3 + SEL_W, 11));
            4: a = a ^ (ADDR_W'(1) << $urandom_range(12, ADDR_W - 1));
            default: ;
        endcase
        return a;
    endfunction

    task automatic cycle(input logic sv, input logic [ADDR_W-1:0] a, input logic [63:0] d,
                         input logic unc, input logic rv, input logic [SEL_W-1:0] rh,
                         input logic [63:0] rd, input logic er);
        logic [REC_W-1:0] got;
        logic [REC_W-1:0] want;
        int c;
        @(negedge clk);
        st_valid = sv; st_addr = a; st_data = d; st_uncached = unc;
        rsp_valid = rv; rsp_handler = rh; rsp_data = rd; ev_ready = er;
        #1;
        s_st_ready = st_ready; s_rsp_ready = rsp_ready; s_ev_valid = ev_valid;
        got = {ev_type, ev_handler, ev_payload};
        s_rec = got;
        chk(err_count == CNT_W'(exp_err), "R4 err_count", 96'(err_count), 96'(exp_err));
        if (prev_stall) begin
            chk(ev_valid && got == prev_rec, "R7 held record", 96'(got), 96'(prev_rec));
        end
        if (ev_valid && !ev_ready) begin
            chk(!st_ready && !rsp_ready, "R8 inputs held off", 96'({st_ready, rsp_ready}), 96'(0));
        end
        if (rv) chk(!st_ready, "R6 store blocked by response", 96'(st_ready), 96'(0));
        if (ev_valid && ev_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected event", 96'(got), 96'(0));
            end else begin
                want = exp_q.pop_front();
                chk(got == want, want[REC_W-1] ? "R5 response record" : "R2 hint record",
                    96'(got), 96'(want));
            end
        end
        prev_stall = ev_valid && !ev_ready;
        prev_rec = got;
        if (rv && rsp_ready) exp_q.push_back({1'b1, rh, rd});
        if (sv && st_ready) begin
            c = classify(a, unc);
            if (c == 1) exp_q.push_back({1'b0, a[3+:SEL_W], d});
            if (c == 2 && exp_err < (1 << CNT_W) - 1) exp_err++;
        end
    endtask

    task automatic idle(input logic er);
        cycle(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, er);
    endtask

    initial begin
        void'($urandom(32'd20251202));
        repeat (3) @(posedge clk);
        #1;
        chk(!ev_valid && err_count == 0, "R1 reset state", 96'({ev_valid, err_count}), 96'(0));
        @(negedge clk);
        rst_n = 1'b1;
        idle(1'b1);
        chk(s_st_ready && s_rsp_ready && !s_ev_valid, "R1 ready after reset",
            96'({s_st_ready, s_rsp_ready, s_ev_valid}), 96'(3'b110));

        // R9 latency and back-to-back throughput, boundary selectors 0 and N-1
        cycle(1'b1, mk_addr(0, 0), 64'h1111_2222_3333_4444, 1'b1, 1'b0, '0, '0, 1'b1);
        cycle(1'b1, mk_addr(0, N - 1), 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b0, '0, '0, 1'b1);
        chk(s_ev_valid && s_rec == {1'b0, SEL_W'(0), 64'h1111_2222_3333_4444},
            "R9 event next cycle", 96'(s_rec), 96'({1'b0, SEL_W'(0), 64'h1111_2222_3333_4444}));
        idle(1'b1);
        chk(s_ev_valid && s_rec == {1'b0, SEL_W'(N - 1), 64'hAAAA_BBBB_CCCC_DDDD},
            "R9 back-to-back", 96'(s_rec), 96'({1'b0, SEL_W'(N - 1), 64'hAAAA_BBBB_CCCC_DDDD}));
        idle(1'b1);

        // R6 collision: response wins
        cycle(1'b1, mk_addr(0, 5), 64'h5, 1'b1, 1'b1, 4'd9, 64'h9999, 1'b1);
        chk(!s_st_ready && s_rsp_ready, "R6 response first", 96'({s_st_ready, s_rsp_ready}), 96'(2'b01));
        cycle(1'b1, mk_addr(0, 5), 64'h5, 1'b1, 1'b0, '0, '0, 1'b1);
        idle(1'b1);

        // R7/R8 long stall
        cycle(1'b1, mk_addr(0, 3), 64'h3333, 1'b1, 1'b0, '0, '0, 1'b0);
        for (int i = 0; i < 5; i++) cycle(1'b1, mk_addr(0, 4), 64'h4444, 1'b1, 1'b1, 4'd2, 64'h2222, 1'b0);
        chk(s_ev_valid && !s_st_ready && !s_rsp_ready, "R8 stalled", 96'({s_ev_valid, s_st_ready, s_rsp_ready}), 96'(3'b100));
        for (int i = 0; i < 4; i++) idle(1'b1);

        // R3 ignored stores, R4 malformed ones incl. selector N
        cycle(1'b1, mk_addr(4, 1), 64'h7, 1'b1, 1'b0, '0, '0, 1'b1);
        cycle(1'b1, mk_addr(0, 1), 64'h8, 1'b0, 1'b0, '0, '0, 1'b1);
        idle(1'b1);
        chk(!s_ev_valid && err_count == 0, "R3 ignored store", 96'({s_ev_valid, err_count}), 96'(0));
        cycle(1'b1, BASE | ADDR_W'(N << 3), 64'h9, 1'b1, 1'b0, '0, '0, 1'b1);
        cycle(1'b1, mk_addr(1, 2), 64'h9, 1'b1, 1'b0, '0, '0, 1'b1);
        cycle(1'b1, mk_addr(3, 2), 64'h9, 1'b1, 1'b0, '0, '0, 1'b1);
        idle(1'b1);
        chk(!s_ev_valid && err_count == 3, "R4 malformed dropped", 96'({s_ev_valid, err_count}), 96'(3));

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int k;
            logic sv, rv, er;
            k = $urandom_range(0, 9);
            sv = ($urandom_range(0, 9) < 7);
            rv = ($urandom_range(0, 3) == 0);
            er = ($urandom_range(0, 3) != 0);
            cycle(sv, mk_addr(k < 5 ? 0 : k - 4, $urandom_range(0, N - 1)),
                  {$urandom, $urandom}, ($urandom_range(0, 7) != 0), rv,
                  SEL_W'($urandom), {$urandom, $urandom}, er);
        end
        for (int i = 0; i < 4; i++) idle(1'b1);
        chk(exp_q.size() == 0, "R8 all events delivered", 96'(exp_q.size()), 96'(0));

        // R10 saturation
        for (int i = 0; i < 300; i++) cycle(1'b1, mk_addr(2, 0), 64'h0, 1'b1, 1'b0, '0, '0, 1'b1);
        idle(1'b1);
        chk(&err_count, "R10 saturated", 96'(err_count), 96'({CNT_W{1'b1}}));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule